// File: doc/BRIEF.md
# Thermistor Tracking Thermal Foldback

This block measures the resistance of an external NTC thermistor network with a digital tracking loop. An 8-bit programmable current source feeds the pin, and an analog comparator reports whether the pin voltage is above a 1.25 V reference. On every sample strobe the loop moves the current code one step toward balance. At equilibrium the code equals the network conductance in steps of 250 nS, so the code is roughly 4 MΩ divided by the resistance. A hotter thermistor has a lower resistance and gives a higher code.

The code goes through two first-order IIR filters built from shifts and adds. The slow filter, with a long time constant, sets an 8-bit LED current scale. The scale is full at or below the 20.3 kΩ point (code 197, about 95 °C) and falls linearly to zero at the 16.26 kΩ point (code 246, about 125 °C). The fast filter drives a shutdown flag that is not latched. It sets at code 246 and clears only once the code drops below 208 (19.23 kΩ, about 110 °C). Tracking continues during shutdown. A ready flag holds the converter off after reset until an acquisition window has elapsed and the fast reading is below the 110 °C code.

Top module: `thermal_foldback`

## Requirements
- R1: While rst_n is low, dac_code_o is 0, scale_o is 255, shutdown_o is 0 and ready_o is 0.
- R2: At a clock edge with sample_i high, dac_code_o decreases by one if cmp_above_i is 1 and increases by one if it is 0. With sample_i low, dac_code_o does not change.
- R3: dac_code_o saturates: it stays at 0 on a step down and at 255 on a step up.
- R4: For a network of resistance R, the code settles to within one step of 4 MΩ / R, for example 40 or 41 for 100 kΩ.
- R5: scale_o is 255 while the slow-filtered code is at most 197 and shutdown_o is low.
- R6: For a slow-filtered code s with 197 < s < 246, scale_o is floor((246 - s) * 255 / 49).
- R7: scale_o is 0 when the slow-filtered code is 246 or more.
- R8: shutdown_o sets on a strobe where the fast-filtered code is 246 or more. Once set, it stays high until a strobe where the fast-filtered code is below 208.
- R9: scale_o is 0 whenever shutdown_o is high.
- R10: ready_o rises only after ACQ_STROBES strobes since reset, on a strobe where the fast-filtered code is below 208 and shutdown_o is low. Once high, it stays high until reset.
- R11: Each filter updates only on a strobe, as acc' = acc + code - (acc >> SH), and reads out acc >> SH, using the code held before that strobe. SH is 2 on the fast path and 6 on the slow path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Sample strobe, one cycle per tracking step |
| cmp_above_i | input | 1 | Comparator: pin voltage above the reference |
| dac_code_o | output | 8 | Current source code, equal to the conductance in 250 nS steps |
| scale_o | output | 8 | LED current scale, 255 = 100 % |
| shutdown_o | output | 1 | Thermal shutdown request |
| ready_o | output | 1 | Startup permission for the converter |

## Verification
Thermal shutdown and linear derating both act on scale_o, and they can meet in the same cycle. A step from a warm resistance to 15 kΩ makes the fast path trip while the slow path still lags inside the derating band. Scale must then drop to zero on exactly the edge where shutdown rises. A behavioural model predicts both paths on every clock and judges this. It also covers the strobe edge where the code step and both filter updates happen together, which shows whether the filters take the old code.

// File: rtl/thermfb_pkg.sv
package thermfb_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/thermfb_track.sv
module thermfb_track #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample_i,
    input  logic         above_i,
    output logic [W-1:0] code_o
);
    import thermfb_pkg::*;

    typedef struct packed {
        logic [W-1:0] code;
    } trk_t;

    trk_t  st_d, st_q;
    step_e step;

    always_comb begin
        st_d = st_q;
        if (!sample_i)     step = STEP_HOLD;
        else if (above_i)  step = STEP_DOWN;
        else               step = STEP_UP;
        case (step)
            STEP_DOWN: if (st_q.code != '0) st_d.code = st_q.code - 1'b1;
            STEP_UP:   if (st_q.code != '1) st_d.code = st_q.code + 1'b1;
            default:   st_d.code = st_q.code;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;
endmodule

// File: rtl/thermfb_iir.sv
module thermfb_iir #(
    parameter int W  = 8,
    parameter int SH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] x_i,
    output logic [W-1:0] y_o
);
    localparam int AW = W + SH;

    typedef struct packed {
        logic [AW-1:0] acc;
    } iir_t;

    iir_t st_d, st_q;

    // acc stays within (2^W-1)*2^SH, so AW bits never overflow
    always_comb begin
        st_d = st_q;
        if (en_i)
            st_d.acc = st_q.acc - (st_q.acc >> SH) + {{SH{1'b0}}, x_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y_o = st_q.acc[AW-1:SH];
endmodule

// File: rtl/thermfb_guard.sv
module thermfb_guard #(
    parameter int W     = 8,
    parameter int TRIP  = 246,
    parameter int CLEAR = 208,
    parameter int ACQ   = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] fast_i,
    output logic         shutdown_o,
    output logic         ready_o
);
    localparam int           CW      = $clog2(ACQ + 1);
    localparam logic [W-1:0] TRIP_C  = W'(TRIP);
    localparam logic [W-1:0] CLEAR_C = W'(CLEAR);
    localparam logic [CW-1:0] ACQ_C  = CW'(ACQ);

    typedef struct packed {
        logic          sd;
        logic          rdy;
        logic [CW-1:0] cnt;
    } grd_t;

    grd_t st_d, st_q;
    logic hot, cool;

    always_comb begin
        st_d = st_q;
        hot  = fast_i >= TRIP_C;
        cool = fast_i <  CLEAR_C;
        if (en_i) begin
            st_d.sd = st_q.sd ? !cool : hot;
            if (st_q.cnt != ACQ_C) st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == ACQ_C && cool && !st_q.sd) st_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shutdown_o = st_q.sd;
    assign ready_o    = st_q.rdy;
endmodule

// File: rtl/thermfb_derate.sv
module thermfb_derate #(
    parameter int W    = 8,
    parameter int KNEE = 197,
    parameter int TRIP = 246
) (
    input  logic [W-1:0] slow_i,
    input  logic         shutdown_i,
    output logic [W-1:0] scale_o
);
    localparam int             SPAN   = TRIP - KNEE;
    localparam logic [W-1:0]   KNEE_C = W'(KNEE);
    localparam logic [W-1:0]   TRIP_C = W'(TRIP);
    localparam logic [2*W-1:0] FULL_W = (2*W)'((1 << W) - 1);
    localparam logic [2*W-1:0] SPAN_W = (2*W)'(SPAN);

    always_comb begin
        if (shutdown_i || slow_i >= TRIP_C)
            scale_o = '0;
        else if (slow_i <= KNEE_C)
            scale_o = '1;
        else
            scale_o = W'(((2*W)'(TRIP_C - slow_i) * FULL_W) / SPAN_W);
    end
endmodule

// File: rtl/thermal_foldback.sv
module thermal_foldback #(
    parameter int CODE_W      = 8,
    parameter int FAST_SH     = 2,
    parameter int SLOW_SH     = 6,
    parameter int KNEE_CODE   = 197,
    parameter int TRIP_CODE   = 246,
    parameter int CLEAR_CODE  = 208,
    parameter int ACQ_STROBES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              cmp_above_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic [CODE_W-1:0] scale_o,
    output logic              shutdown_o,
    output logic              ready_o
);
    logic [CODE_W-1:0] code, fast_y, slow_y;

    thermfb_track #(.W(CODE_W)) u_track (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
        .above_i(cmp_above_i), .code_o(code)
    );

    thermfb_iir #(.W(CODE_W), .SH(FAST_SH)) u_fast (
        .clk(clk), .rst_n(rst_n), .en_i(sample_i), .x_i(code), .y_o(fast_y)
    );

    thermfb_iir #(.W(CODE_W), .SH(SLOW_SH)) u_slow (
        .clk(clk), .rst_n(rst_n), .en_i(sample_i), .x_i(code), .y_o(slow_y)
    );

    thermfb_guard #(.W(CODE_W), .TRIP(TRIP_CODE), .CLEAR(CLEAR_CODE),
                    .ACQ(ACQ_STROBES)) u_guard (
        .clk(clk), .rst_n(rst_n), .en_i(sample_i), .fast_i(fast_y),
        .shutdown_o(shutdown_o), .ready_o(ready_o)
    );

    thermfb_derate #(.W(CODE_W), .KNEE(KNEE_CODE), .TRIP(TRIP_CODE)) u_derate (
        .slow_i(slow_y), .shutdown_i(shutdown_o), .scale_o(scale_o)
    );

    assign dac_code_o = code;
endmodule

// File: rtl/thermfb_chk.sv
module thermfb_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sample_i,
    input logic         cmp_above_i,
    input logic [W-1:0] dac_code_o,
    input logic [W-1:0] scale_o,
    input logic         shutdown_o,
    input logic         ready_o
);
    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i && cmp_above_i && dac_code_o != '0 |=> dac_code_o == $past(dac_code_o) - 1'b1);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(dac_code_o));

    // R3
    top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i && !cmp_above_i && dac_code_o == '1 |=> dac_code_o == '1);

    // R3
    low_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i && cmp_above_i && dac_code_o == '0 |=> dac_code_o == '0);

    // R9
    sd_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |-> scale_o == '0);

    // R10
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

    // R10
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> !shutdown_o);
endmodule

bind thermal_foldback thermfb_chk #(.W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .cmp_above_i(cmp_above_i),
    .dac_code_o(dac_code_o), .scale_o(scale_o), .shutdown_o(shutdown_o),
    .ready_o(ready_o)
);

// File: tb/thermal_foldback_bench.sv
`timescale 1ns/1ps
module thermal_foldback_bench;
    localparam int FS = 2, SS = 6, ACQ = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample = 1'b0;
    logic       cmp;
    logic [7:0] dac, scale;
    logic       sd, rdy;

    int r_ohm = 100000;
    int force_mode = 0;
    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    // model state
    int m_code = 0, m_fa = 0, m_sa = 0, m_sd = 0, m_rdy = 0, m_cnt = 0;

    always #10 clk = ~clk;

    // analog pin model: voltage above 1.25 V when code*0.3125uA*R > 1.25 V
    assign cmp = (force_mode == 1) ? 1'b1 :
                 (force_mode == 2) ? 1'b0 :
                 ((int'(dac) * r_ohm) > 4000000);

    thermal_foldback u_thermal_foldback (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .cmp_above_i(cmp),
        .dac_code_o(dac), .scale_o(scale), .shutdown_o(sd), .ready_o(rdy)
    );

    function automatic int exp_scale(int s, int shut);
        if (shut != 0) return 0;
        if (s <= 197)  return 255;
        if (s >= 246)  return 0;
        return (246 - s) * 255 / 49;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 0; m_fa = 0; m_sa = 0; m_sd = 0; m_rdy = 0; m_cnt = 0;
        end else if (sample) begin
            int ff;
            int old;
            ff  = m_fa >> FS;
            old = m_code;
            if (cmp) begin if (m_code > 0) m_code = m_code - 1; end
            else     begin if (m_code < 255) m_code = m_code + 1; end
            m_fa = m_fa + old - (m_fa >> FS);
            m_sa = m_sa + old - (m_sa >> SS);
            if (m_cnt == ACQ && ff < 208 && m_sd == 0) m_rdy = 1;
            m_sd = (m_sd != 0) ? int'(ff >= 208) : int'(ff >= 246);
            if (m_cnt < ACQ) m_cnt = m_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(dac) == m_code, "R2 dac code vs model", int'(dac), m_code);
            chk(int'(scale) == exp_scale(m_sa >> SS, m_sd), "R11 scale vs model",
                int'(scale), exp_scale(m_sa >> SS, m_sd));
            chk(int'(sd) == m_sd, "R8 shutdown vs model", int'(sd), m_sd);
            chk(int'(rdy) == m_rdy, "R10 ready vs model", int'(rdy), m_rdy);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sample = 1'b1;
            @(negedge clk) sample = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(dac == 8'd0 && scale == 8'd255 && !sd && !rdy, "R1 reset state",
            int'({dac, scale, sd, rdy}), int'({8'd0, 8'd255, 1'b0, 1'b0}));
        rst_n = 1'b1;
    endtask

    initial begin
        int prev;
        do_reset();
        // cold: 100k -> code 40
        r_ohm = 100000;
        strobes(400);
        chk(dac == 8'd40 || dac == 8'd41, "R4 settle at 100k", int'(dac), 40);
        chk(rdy == 1'b1, "R10 ready after acquisition", int'(rdy), 1);
        chk(scale == 8'd255, "R5 full scale when cold", int'(scale), 255);

        // forced single steps
        @(negedge clk) force_mode = 1;
        prev = int'(dac);
        strobes(1);
        chk(int'(dac) == prev - 1, "R2 step down", int'(dac), prev - 1);
        force_mode = 2;
        prev = int'(dac);
        strobes(1);
        chk(int'(dac) == prev + 1, "R2 step up", int'(dac), prev + 1);
        prev = int'(dac);
        repeat (12) @(negedge clk);
        chk(int'(dac) == prev, "R2 hold without strobe", int'(dac), prev);
        force_mode = 0;

        // derating band: 18k -> code 222
        r_ohm = 18000;
        strobes(200);
        chk(dac == 8'd222 || dac == 8'd223, "R4 settle at 18k", int'(dac), 222);
        chk(scale > 8'd140, "R11 slow path still lagging", int'(scale), 141);
        strobes(600);
        chk(scale >= 8'd115 && scale <= 8'd135, "R6 linear derate", int'(scale), 124);
        chk(sd == 1'b0, "R8 no shutdown in band", int'(sd), 0);

        // overheated: 15k -> saturate at 255, shutdown
        r_ohm = 15000;
        strobes(600);
        chk(dac == 8'd255, "R3 saturate high", int'(dac), 255);
        chk(sd == 1'b1, "R8 shutdown set", int'(sd), 1);
        chk(scale == 8'd0, "R7 R9 zero scale when hot", int'(scale), 0);

        // hysteresis: 17.5k -> code 228 stays in shutdown
        r_ohm = 17500;
        strobes(600);
        chk(sd == 1'b1, "R8 shutdown held in hysteresis", int'(sd), 1);
        chk(dac == 8'd228 || dac == 8'd229, "R4 settle at 17.5k", int'(dac), 228);

        // cooled: 25k -> code 160
        r_ohm = 25000;
        strobes(800);
        chk(sd == 1'b0, "R8 shutdown cleared", int'(sd), 0);
        chk(scale == 8'd255, "R5 full scale restored", int'(scale), 255);
        chk(rdy == 1'b1, "R10 ready held", int'(rdy), 1);

        // low saturation
        @(negedge clk) force_mode = 1;
        strobes(300);
        chk(dac == 8'd0, "R3 saturate low", int'(dac), 0);
        force_mode = 0;

        // start-up hold-off while hot
        r_ohm = 15000;
        do_reset();
        strobes(400);
        chk(rdy == 1'b0, "R10 ready withheld while hot", int'(rdy), 0);
        chk(sd == 1'b1, "R8 shutdown during hot start", int'(sd), 1);
        r_ohm = 100000;
        strobes(600);
        chk(rdy == 1'b1, "R10 ready after cooling", int'(rdy), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule